// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter with very low power draw. It produces an active-low chip select and a serial clock, and it reads the converter's data line. Each conversion frame is 16 serial clocks long. The converter uses these clock edges to do its conversion and to shift out the data. A frame holds four zero bits and then the twelve result bits, most significant bit first. The controller assembles the result, raises a one-cycle valid strobe, and flags a frame error if any of the leading bits is not zero.

The serial clock rate comes from an integer half-period divider on the system clock. The frame rate comes from a period counted in serial clock periods. Between frames, chip select stays high, so the converter sits in power-down for the rest of each period. A configuration check enforces a minimum quiet time. An abort input ends a frame early. The converter treats an early chip-select rise as a cancelled conversion.

Top module: `adc_serial_reader`

## Requirements
- R1: During and after reset, `cs_n` and `sclk` are 1 and `result_valid` is 0.
- R2: In every frame that is not aborted, exactly 16 falling `sclk` edges occur while `cs_n` is low. `cs_n` rises in the same clock as the `sclk` rise that follows the 16th falling edge.
- R3: Each low and high phase of `sclk` inside a frame lasts `half_div` system clocks. A `half_div` of 0 raises `cfg_err`.
- R4: `sdata` is captured in the clock where `sclk` is driven low, which is before the converter advances its data. Capture k (k = 1..16) holds frame bit 16-k. `result` equals captures 5..16 with the MSB first. `result_valid` pulses for one clock, in the clock of the 16th falling edge.
- R5: `frame_err` is 1 together with `result_valid` exactly when any of captures 1..4 was 1.
- R6: Consecutive falling edges of `cs_n` are 2·`period`·`half_div` system clocks apart, and an abort does not shift this spacing.
- R7: `cfg_err` is 1 when `period` < 16 + `quiet`. While `cfg_err` is 1, `cs_n` stays high. Otherwise `cs_n` stays high for at least 2·`quiet`·`half_div` clocks between frames.
- R8: When `abort` is 1 while `cs_n` is low, `cs_n` and `sclk` are 1 on the next clock, and that frame produces no `result_valid`.
- R9: `abort` while `cs_n` is high has no effect on `cs_n` or on the frame timing.
- R10: `sclk` is 1 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Serial clock half period in system clocks |
| period | input | PER_W | Frame period in serial clock periods |
| quiet | input | PER_W | Minimum chip-select-high time in serial clock periods |
| abort | input | 1 | Ends the current frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result | output | 12 | Last conversion result |
| result_valid | output | 1 | One-clock strobe for a new result |
| frame_err | output | 1 | Leading-bit error of the last result |
| cfg_err | output | 1 | Configuration is unusable |

## Verification
Outputs are read on the falling system-clock edge. The `result_valid` strobe is expected in the same clock where the 16th `sclk` low is driven. The `cs_n` rise is expected half_div clocks later. After an abort, `cs_n` must be high at the very next sample. A scoreboard queue pairs each converter word the driver loads with the next strobe. A monitor timestamps the chip-select and serial-clock edges and compares each spacing to the exact count derived from `half_div`, `period` and `quiet`. Timing checks that an abort or a configuration change makes meaningless are skipped for that one frame.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DIV_W = 8,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] quiet,
  input  logic             abort,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic [11:0]      result,
  output logic             result_valid,
  output logic             frame_err,
  output logic             cfg_err
);
  localparam int HW       = PER_W + 2;
  localparam int LAST_CAP = 31;
  localparam int END_HALF = 32;

  logic [DIV_W-1:0] div_cnt;
  logic [HW-1:0]    half_idx, half_last, half_nx;
  logic [14:0]      shreg;
  logic             tick;

  assign cfg_err   = (half_div == '0) || ({2'b00, period} < ({2'b00, quiet} + HW'(16)));
  assign tick      = div_cnt >= half_div - 1'b1;
  assign half_last = {1'b0, period, 1'b0} - 1'b1;
  assign half_nx   = (half_idx >= half_last) ? '0 : half_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt      <= '0;
      half_idx     <= '1;
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
      shreg        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      div_cnt      <= tick ? '0 : div_cnt + 1'b1;
      if (tick) half_idx <= half_nx;
      if (cfg_err || (abort && !cs_n)) begin
        cs_n <= 1'b1;
        sclk <= 1'b1;
      end else if (tick) begin
        if (half_nx == '0) begin
          cs_n <= 1'b0;
          sclk <= 1'b1;
        end else if (!cs_n) begin
          if (half_nx >= HW'(END_HALF)) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
          end else begin
            sclk <= ~half_nx[0];
            if (half_nx[0]) begin
              shreg <= {shreg[13:0], sdata};
              if (half_nx == HW'(LAST_CAP)) begin
                result       <= {shreg[10:0], sdata};
                frame_err    <= |shreg[14:11];
                result_valid <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  p_idle_clk_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !cs_n) |=> (cs_n && sclk && !result_valid));
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_valid_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (!cs_n && !sclk));
  p_cfg_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cs_n);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (cs_n && sclk && !result_valid));
endmodule

// File: tb/adc_serial_reader_tb.sv
`timescale 1ns/1ps
module adc_serial_reader_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic [9:0] period = 10'd20, quiet = 10'd2;
  logic abort = 1'b0;
  logic sdata;
  logic cs_n, sclk, result_valid, frame_err, cfg_err;
  logic [11:0] result;

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [12:0] exp_q[$];

  logic [15:0] mdl_word = 16'h0000;
  int mdl_idx = 15;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_serial_reader u_dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .period(period), .quiet(quiet),
    .abort(abort), .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .result(result),
    .result_valid(result_valid), .frame_err(frame_err), .cfg_err(cfg_err));

  // converter model: shifts its word out, advancing after each falling sclk
  always @(negedge cs_n) mdl_idx = 15;
  always @(negedge sclk) if (!cs_n) #1 mdl_idx = mdl_idx - 1;
  assign sdata = (!cs_n && mdl_idx >= 0) ? mdl_word[mdl_idx] : 1'b1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and scoreboard
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  bit abort_flag = 1'b0, was_abort = 1'b1;
  longint last_fall = -1, last_rise = -1, last_sfall = -1;
  int nfall = 0, cs_falls = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_cs && !cs_n) begin
      cs_falls++;
      if (last_fall >= 0) check(cyc - last_fall == 2*period*half_div, "R6 period", cyc - last_fall, 2*period*half_div);
      if (last_rise >= 0) begin
        check(cyc - last_rise >= 2*quiet*half_div, "R7 quiet", cyc - last_rise, 2*quiet*half_div);
        if (!was_abort) check(cyc - last_rise == (2*period-32)*half_div, "R7 gap", cyc - last_rise, (2*period-32)*half_div);
      end
      last_fall = cyc;
      nfall = 0;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      nfall++;
      last_sfall = cyc;
    end
    if (!prev_sclk && sclk && !abort_flag && last_sfall >= 0)
      check(cyc - last_sfall == half_div, "R3 half period", cyc - last_sfall, half_div);
    if (!prev_cs && cs_n) begin
      if (!abort_flag) check(nfall == 16, "R2 falling edges", nfall, 16);
      last_rise = cyc;
      was_abort = abort_flag;
      abort_flag = 1'b0;
    end
    if (cs_n && !sclk) check(1'b0, "R10 sclk idle", sclk, 1);
    if (result_valid) begin
      check(nfall == 16, "R4 strobe timing", nfall, 16);
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected result", result, 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check(result == e[11:0], "R4 result", result, e[11:0]);
        check(frame_err == e[12], "R5 frame_err", frame_err, e[12]);
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic frame(input logic [15:0] w);
    mdl_word = w;
    exp_q.push_back({|w[15:12], w[11:0]});
    @(negedge cs_n);
    @(posedge cs_n);
  endtask

  task automatic frame_abort(input int wait_cyc);
    mdl_word = 16'h0ABC;
    @(negedge cs_n);
    repeat (wait_cyc) @(negedge clk);
    abort_flag = 1'b1;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(cs_n && sclk, "R8 abort release", {cs_n, sclk}, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(cs_n && sclk && !result_valid, "R1 reset state", {cs_n, sclk, result_valid}, 6);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && sclk && !result_valid, "R1 after reset", {cs_n, sclk, result_valid}, 6);
    check(!cfg_err, "R7 cfg ok", cfg_err, 0);
    frame(16'h0A5C);
    frame(16'h0FFF);
    frame(16'h0001);
    frame(16'h8123);
    frame(16'h1800);
    frame_abort(9);
    frame_abort(50);
    frame(16'h0C3A);
    repeat (3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(cs_n, "R9 idle abort", cs_n, 1);
    frame(16'h0555);
    // configuration error: period too short for the quiet time
    @(negedge clk);
    period = 10'd17;
    #1 check(cfg_err, "R7 cfg_err", cfg_err, 1);
    begin
      int f0;
      f0 = cs_falls;
      repeat (300) @(negedge clk);
      check(cs_falls == f0 && cs_n, "R7 idle while cfg_err", cs_falls - f0, 0);
    end
    half_div = 8'd0;
    period = 10'd40;
    #1 check(cfg_err, "R3 zero divider", cfg_err, 1);
    last_fall = -1;
    last_rise = -1;
    last_sfall = -1;
    @(negedge clk);
    half_div = 8'd1;
    period = 10'd18;
    quiet = 10'd2;
    #1 check(!cfg_err, "R7 cfg ok fast", cfg_err, 0);
    frame(16'h0FA0);
    frame(16'h4001);
    frame(16'h0123);
    frame_abort(4);
    frame(16'h0ABD);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule